// File: doc/BRIEF.md
# Reduced-Channel Sample Packer

The packer sits between a logic-capture front end and its sample store. When a capture watches only a few signals, storing one full byte per sample wastes most of each memory word. The packer takes the low 4, 2 or 1 bits of each incoming sample and gathers 2, 4 or 8 successive samples into one 8-bit word. The same memory then holds up to eight times as many samples, and the store can be written at a lower rate than the sample rate. An 8-channel setting passes every sample through untouched as its own byte.

The channel count is chosen at run time on `packMode`. A shift register collects the narrow samples and a fill counter tracks how many slots are occupied. When the last slot is filled, the completed word appears on `byteOut` together with a one-cycle `byteValid` strobe. A change of `packMode`, or a reset, throws away any partly built word so that every stored byte holds samples taken under a single setting.

Top module: `sample_packer`

## Requirements
- R1: With `packMode` = 0 (8 channels), every cycle with `sampleValid` high puts that `sampleIn` byte on `byteOut` with `byteValid` high in the following cycle.
- R2: With `packMode` = 1 (4 channels), two accepted samples make one byte: the earlier sample's bits [3:0] go to `byteOut[3:0]` and the later sample's bits [3:0] go to `byteOut[7:4]`.
- R3: With `packMode` = 2 (2 channels), four accepted samples make one byte: sample k (k = 0 is the earliest) supplies its bits [1:0] to `byteOut[2k+1:2k]`.
- R4: With `packMode` = 3 (1 channel), eight accepted samples make one byte: sample k (k = 0 is the earliest) supplies its bit 0 to `byteOut[k]`.
- R5: `byteValid` is high for exactly one cycle: the cycle after the sample that fills the last slot is accepted. It never rises after a cycle with `sampleValid` low.
- R6: `byteOut` keeps its value in every cycle that does not carry a new `byteValid` pulse.
- R7: In the packed modes, the bits of `sampleIn` above the active channel width have no effect on `byteOut`.
- R8: When `packMode` differs from its value in the previous cycle, the partly filled byte and the fill count are discarded. A sample accepted in that cycle becomes slot 0 of a new byte in the new mode.
- R9: Reset (active-low `rst_n`) clears `byteOut` to 0, holds `byteValid` low and discards any partly filled byte.
- R10: Cycles with `sampleValid` low between samples leave the partial byte and the fill count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| packMode | input | 2 | 0: 8 channels, 1: 4 channels, 2: 2 channels, 3: 1 channel |
| sampleIn | input | 8 | Incoming sample, active channels in the low bits |
| sampleValid | input | 1 | Sample present this cycle |
| byteOut | output | 8 | Most recent completed byte |
| byteValid | output | 1 | One-cycle strobe marking a new byte |

## Verification
The hardest situation to reach is a mode switch that lands on a half-filled byte, with a valid sample in the same cycle as the switch. That sample must start a fresh byte rather than finish the old one. The bench fills three of the eight slots in 1-channel mode. It then changes to 4-channel mode and presents a sample in the same cycle. It checks that no byte is emitted and that the next byte holds only the two post-switch nibbles. A reset issued in the middle of a byte is driven the same way, and idle gaps are placed inside a byte to show that the fill count holds still while `sampleValid` is low.

// File: rtl/pack_pkg.sv
`timescale 1ns/1ps
package pack_pkg;
  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic clearAcc;  // discard partial byte (mode changed)
    logic take;      // accept sampleIn into the accumulator
    logic emit;      // this sample completes the byte
  } packStrobe_t;
endpackage

// File: rtl/pack_ctrl.sv
`timescale 1ns/1ps
module pack_ctrl
  import pack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] packMode,
  input  logic              sampleValid,
  output packStrobe_t       strobe
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [MODE_W-1:0] lastMode;
  logic [CNT_W-1:0]  fillCnt;
  logic [CNT_W-1:0]  effCnt;
  logic [CNT_W-1:0]  lastSlot;
  logic [CNT_W:0]    slotsPerByte;
  logic              modeChange;

  always_comb begin
    modeChange      = (packMode != lastMode);
    effCnt          = modeChange ? '0 : fillCnt;
    slotsPerByte    = ONE << packMode;
    lastSlot        = CNT_W'(slotsPerByte - ONE);
    strobe.clearAcc = modeChange;
    strobe.take     = sampleValid;
    strobe.emit     = sampleValid && (effCnt == lastSlot);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastMode <= '0;
      fillCnt  <= '0;
    end else begin
      lastMode <= packMode;
      if (strobe.take) begin
        fillCnt <= strobe.emit ? '0 : effCnt + 1'b1;
      end else begin
        fillCnt <= effCnt;
      end
    end
  end
endmodule

// File: rtl/pack_datapath.sv
`timescale 1ns/1ps
module pack_datapath
  import pack_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MODE_W    = 2,
  parameter int NUM_MODES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] packMode,
  input  logic [DATA_W-1:0] sampleIn,
  input  packStrobe_t       strobe,
  output logic [DATA_W-1:0] byteOut,
  output logic              byteValid
);
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] nextAcc;
  logic [DATA_W-1:0] cand [NUM_MODES];

  assign base = strobe.clearAcc ? '0 : acc;

  // One insertion path per mode: new sample enters at the top, older
  // samples move down, so the earliest ends in the least significant slot.
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int W = DATA_W >> m;
    if (W == DATA_W) begin : g_pass
      assign cand[m] = sampleIn;
    end else begin : g_shift
      assign cand[m] = {sampleIn[W-1:0], base[DATA_W-1:W]};
    end
  end

  assign nextAcc = cand[packMode];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      byteOut   <= '0;
      byteValid <= 1'b0;
    end else begin
      acc       <= strobe.take ? nextAcc : base;
      byteValid <= strobe.emit;
      if (strobe.emit) begin
        byteOut <= nextAcc;
      end
    end
  end
endmodule

// File: rtl/sample_packer.sv
`timescale 1ns/1ps
module sample_packer
  import pack_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] packMode,
  input  logic [7:0] sampleIn,
  input  logic       sampleValid,
  output logic [7:0] byteOut,
  output logic       byteValid
);
  localparam int NUM_MODES = $clog2(DATA_W) + 1;
  localparam int MODE_W    = $clog2(NUM_MODES);
  localparam int CNT_W     = $clog2(DATA_W);

  packStrobe_t strobe;

  pack_ctrl #(.DATA_W(DATA_W), .MODE_W(MODE_W), .CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .packMode   (packMode),
    .sampleValid(sampleValid),
    .strobe     (strobe)
  );

  pack_datapath #(.DATA_W(DATA_W), .MODE_W(MODE_W), .NUM_MODES(NUM_MODES)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .packMode (packMode),
    .sampleIn (sampleIn),
    .strobe   (strobe),
    .byteOut  (byteOut),
    .byteValid(byteValid)
  );
endmodule

// File: rtl/sample_packer_chk.sv
`timescale 1ns/1ps
module sample_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] packMode,
  input logic [7:0] sampleIn,
  input logic       sampleValid,
  input logic [7:0] byteOut,
  input logic       byteValid
);
  // R1: pass-through mode emits each sample the next cycle
  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && packMode == 2'd0) |=> (byteValid && byteOut == $past(sampleIn)));

  // R5: no strobe without an accepted sample
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> !byteValid);

  // R5: in packed modes a strobe is never followed by another unless pass-through
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byteValid && packMode != 2'd0) |=> (!byteValid || packMode == 2'd0));

  // R6: output holds when no sample arrives
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> $stable(byteOut));
endmodule

bind sample_packer sample_packer_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .packMode   (packMode),
  .sampleIn   (sampleIn),
  .sampleValid(sampleValid),
  .byteOut    (byteOut),
  .byteValid  (byteValid)
);

// File: tb/sample_packer_tb_top.sv
`timescale 1ns/1ps
module sample_packer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] packMode = 2'd0;
  logic [7:0] sampleIn = 8'd0;
  logic       sampleValid = 1'b0;
  logic [7:0] byteOut;
  logic       byteValid;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sample_packer dut_i (
    .clk(clk), .rst_n(rst_n), .packMode(packMode), .sampleIn(sampleIn),
    .sampleValid(sampleValid), .byteOut(byteOut), .byteValid(byteValid)
  );

  // Drive at falling edge, observe just after the rising edge.
  task automatic step(input logic [1:0] m, input logic v, input logic [7:0] d);
    @(negedge clk);
    packMode = m; sampleValid = v; sampleIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic expV, input logic [7:0] expB);
    checks++;
    if (byteValid !== expV || byteOut !== expB) begin
      errors++;
      $display("FAIL %s: got valid=%0b byte=%02h, expected valid=%0b byte=%02h",
               tag, byteValid, byteOut, expV, expB);
    end
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    step(2'd0, 1'b0, 8'h00);
    step(2'd0, 1'b0, 8'h00);
    check("R9 reset state", 1'b0, 8'h00);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic testPassThru();
    step(2'd0, 1'b1, 8'hA5); check("R1 pass first", 1'b1, 8'hA5);
    step(2'd0, 1'b1, 8'h3C); check("R1 pass back-to-back", 1'b1, 8'h3C);
    step(2'd0, 1'b0, 8'hFF); check("R5 R6 idle after pass", 1'b0, 8'h3C);
  endtask

  // Packs a full byte in mode m; upper bits carry garbage (R7).
  task automatic testPack(input logic [1:0] m, input string tag, input logic [7:0] seed);
    int w = 8 >> m;
    int n = 1 << m;
    logic [7:0] mask = 8'((16'd1 << w) - 1);
    logic [7:0] expB = 8'h00;
    logic [7:0] prev = byteOut;
    for (int i = 0; i < n; i++) begin
      logic [7:0] s = 8'(seed + i * 37) | ~mask;
      expB = expB | 8'((16'(s & mask)) << (i * w));
      step(m, 1'b1, s);
      if (i < n - 1) check({tag, " partial, R6 hold"}, 1'b0, prev);
    end
    check({tag, " full byte, R7 upper bits ignored"}, 1'b1, expB);
    step(m, 1'b0, 8'h00);
    check({tag, " R5 single pulse"}, 1'b0, expB);
  endtask

  task automatic testIdleGaps();
    step(2'd2, 1'b1, 8'h03); check("R10 gap slot0", 1'b0, byteOut);
    step(2'd2, 1'b0, 8'hFF); step(2'd2, 1'b0, 8'hFF);
    step(2'd2, 1'b1, 8'h00);
    step(2'd2, 1'b0, 8'hFF);
    step(2'd2, 1'b1, 8'h02);
    step(2'd2, 1'b1, 8'h01);
    check("R10 byte with gaps", 1'b1, 8'h63);
  endtask

  task automatic testModeChange();
    logic [7:0] prev;
    step(2'd3, 1'b1, 8'h01);
    step(2'd3, 1'b1, 8'h01);
    step(2'd3, 1'b1, 8'h01);
    prev = byteOut;
    step(2'd1, 1'b1, 8'h5A); check("R8 no byte on switch", 1'b0, prev);
    step(2'd1, 1'b1, 8'h3C); check("R8 fresh byte after switch", 1'b1, 8'hCA);
  endtask

  task automatic testResetMid();
    step(2'd1, 1'b1, 8'h07);
    rst_n = 1'b0;
    step(2'd1, 1'b0, 8'h00);
    check("R9 mid-byte reset clears", 1'b0, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    step(2'd1, 1'b1, 8'h01); check("R9 no leftover slot", 1'b0, 8'h00);
    step(2'd1, 1'b1, 8'h02); check("R9 R2 byte after reset", 1'b1, 8'h21);
  endtask

  initial begin
    testReset();
    testPassThru();
    testPack(2'd1, "R2 4ch", 8'h19);
    testPack(2'd2, "R3 2ch", 8'h4E);
    testPack(2'd3, "R4 1ch", 8'h0D);
    testPack(2'd3, "R4 1ch again", 8'h72);
    testIdleGaps();
    testModeChange();
    testResetMid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule